// File: doc/BRIEF.md
# ADC Regular-Group Scan Sequencer

This block steps an analog-to-digital converter through a programmed list of up to sixteen channel numbers. The list entries and a length field are static configuration inputs. A trigger launches work. The sequencer hands the converter core one channel at a time. Each request is a single-cycle start strobe with a channel number. The sequencer then waits for the core's done strobe before it issues the next request. After every conversion it raises a one-cycle end-of-conversion flag. After the final list entry it also raises an end-of-sequence flag.

Two operating modes exist. In whole-list mode, every accepted trigger runs the entire list from the first entry. In split mode, a trigger runs only a sub-group of 1 to 8 entries. The sequencer then parks and waits for the next trigger, which resumes at the following entry. A sub-group that would run past the end of the list is cut short at the last entry, and the sequence then starts again at entry 0. Dropping the split-mode enable abandons any sub-group in flight and rewinds to entry 0.

Top module: `adc_scan_seq`

## Requirements
- R1: After reset, conv_start, eoc and eos are low, and the first accepted trigger starts with list entry 0.
- R2: With split_en low, a trigger sampled while idle produces conv_start in the next cycle. The sequencer then requests entries 0..seq_len in order, seq_len+1 entries in total. Entry i is seq_list[i*5+4:i*5].
- R3: conv_start is high for exactly one cycle per request, and no new request is issued until conv_done has answered the previous one.
- R4: eoc pulses for one cycle, in the cycle after each conv_done that answers an outstanding request, and at no other time.
- R5: eos is high only together with the eoc of the last list entry (index seq_len), in either mode.
- R6: With split_en high, each accepted trigger requests the next grp_size+1 entries (1 to 8). Position is kept between triggers.
- R7: In split mode, a sub-group that reaches the last entry stops there even if it is shorter than grp_size+1. The next trigger resumes at entry 0.
- R8: A trigger that arrives while a request or sub-group is in progress is dropped. It is not stored and does not start extra conversions afterwards.
- R9: A falling split_en, or reset, aborts the work in progress and rewinds to entry 0. A conv_done that arrives after the abort gives no eoc.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| split_en | input | 1 | Selects split (sub-group) mode when high |
| grp_size | input | 3 | Sub-group size minus one |
| seq_len | input | 4 | List length minus one |
| seq_list | input | 80 | Sixteen 5-bit channel entries; entry i at bits i*5+4:i*5 |
| trig | input | 1 | Trigger strobe |
| conv_done | input | 1 | Converter finished the outstanding request |
| conv_start | output | 1 | One-cycle conversion request |
| conv_ch | output | 5 | Channel for the request, valid with conv_start |
| eoc | output | 1 | End-of-conversion pulse |
| eos | output | 1 | End-of-sequence pulse |

## Verification
Some properties are checked on every cycle by the bound checker:
- the handshake: a single-cycle start, and never two requests without a done between them;
- the timing of eoc after a done;
- that eos never appears without eoc;
- the silence that follows an abort.

Other behaviour depends on the list contents and on the position kept across triggers, so only the bench scenarios can show it. This covers which channel each request carries, where a sub-group stops, the shortened final group, the wrap to entry 0, and dropped triggers. The bench checks these against a model of the list position, under randomized configurations and directed corner cases.

// File: rtl/adc_scan_seq_pkg.sv
package adc_scan_seq_pkg;

   typedef enum logic [1:0] {
      SEQ_IDLE  = 2'd0,
      SEQ_ISSUE = 2'd1,
      SEQ_WAIT  = 2'd2
   } seq_state_t;

endpackage

// File: rtl/adc_seq_cursor.sv
module adc_seq_cursor #(
   parameter int LEN_W = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clear,
   input  logic             step,
   input  logic [LEN_W-1:0] last_idx,
   output logic [LEN_W-1:0] pos,
   output logic             at_last
);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pos <= '0;
      end else if (clear) begin
         pos <= '0;
      end else if (step) begin
         pos <= pos + 1'b1;
      end
   end

   // >= keeps the cursor safe if the length field shrinks mid-list
   assign at_last = (pos >= last_idx);

endmodule

// File: rtl/adc_seq_grpcnt.sv
module adc_seq_grpcnt #(
   parameter int GRP_W  = 3,
   parameter bit ENABLE = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clear,
   input  logic             step,
   input  logic [GRP_W-1:0] size_m1,
   output logic             grp_end
);

   generate
      if (ENABLE) begin : g_count
         logic [GRP_W-1:0] cnt;
         always_ff @(posedge clk) begin
            if (!rst_n) begin
               cnt <= '0;
            end else if (clear) begin
               cnt <= '0;
            end else if (step) begin
               cnt <= cnt + 1'b1;
            end
         end
         assign grp_end = (cnt == size_m1);
      end else begin : g_none
         logic unused_ok;
         assign unused_ok = &{1'b0, clk, rst_n, clear, step, size_m1};
         assign grp_end   = 1'b0;
      end
   endgenerate

endmodule

// File: rtl/adc_seq_chsel.sv
module adc_seq_chsel #(
   parameter int CH_W  = 5,
   parameter int LEN_W = 4
) (
   input  logic [(CH_W << LEN_W)-1:0] list_flat,
   input  logic [LEN_W-1:0]           sel,
   output logic [CH_W-1:0]            ch
);

   localparam int N_ENT = 1 << LEN_W;

   logic [CH_W-1:0] ent [N_ENT];

   generate
      for (genvar gi = 0; gi < N_ENT; gi++) begin : g_ent
         assign ent[gi] = list_flat[gi*CH_W +: CH_W];
      end
   endgenerate

   assign ch = ent[sel];

endmodule

// File: rtl/adc_scan_seq.sv
module adc_scan_seq
   import adc_scan_seq_pkg::*;
#(
   parameter int CH_W      = 5,
   parameter int LEN_W     = 4,
   parameter int GRP_W     = 3,
   parameter bit SPLIT_OPT = 1'b1,
   localparam int MAX_LEN  = 1 << LEN_W,
   localparam int LIST_W   = CH_W * MAX_LEN
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              split_en,
   input  logic [GRP_W-1:0]  grp_size,
   input  logic [LEN_W-1:0]  seq_len,
   input  logic [LIST_W-1:0] seq_list,
   input  logic              trig,
   input  logic              conv_done,
   output logic              conv_start,
   output logic [CH_W-1:0]   conv_ch,
   output logic              eoc,
   output logic              eos
);

   seq_state_t       state_q, state_d;
   logic             split_q;
   logic             abort;
   logic             accept;
   logic             done_ok;
   logic             at_last;
   logic             grp_end;
   logic             stop_here;
   logic [LEN_W-1:0] pos;

   always_ff @(posedge clk) begin
      if (!rst_n) split_q <= 1'b0;
      else        split_q <= split_en;
   end

   assign abort     = split_q & ~split_en;
   assign accept    = (state_q == SEQ_IDLE) & trig;
   assign done_ok   = (state_q == SEQ_WAIT) & conv_done;
   assign stop_here = at_last | (split_en & grp_end);

   always_comb begin
      state_d = state_q;
      if (abort) begin
         state_d = SEQ_IDLE;
      end else begin
         unique case (state_q)
            SEQ_IDLE:  if (accept)  state_d = SEQ_ISSUE;
            SEQ_ISSUE:              state_d = SEQ_WAIT;
            SEQ_WAIT:  if (done_ok) state_d = stop_here ? SEQ_IDLE : SEQ_ISSUE;
            default:                state_d = SEQ_IDLE;
         endcase
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q <= SEQ_IDLE;
         eoc     <= 1'b0;
         eos     <= 1'b0;
      end else begin
         state_q <= state_d;
         eoc     <= done_ok & ~abort;
         eos     <= done_ok & at_last & ~abort;
      end
   end

   adc_seq_cursor #(.LEN_W(LEN_W)) u_cursor (
      .clk      (clk),
      .rst_n    (rst_n),
      .clear    (abort | (done_ok & at_last)),
      .step     (done_ok & ~at_last & ~abort),
      .last_idx (seq_len),
      .pos      (pos),
      .at_last  (at_last)
   );

   adc_seq_grpcnt #(.GRP_W(GRP_W), .ENABLE(SPLIT_OPT)) u_grpcnt (
      .clk     (clk),
      .rst_n   (rst_n),
      .clear   (accept | abort),
      .step    (done_ok),
      .size_m1 (grp_size),
      .grp_end (grp_end)
   );

   adc_seq_chsel #(.CH_W(CH_W), .LEN_W(LEN_W)) u_chsel (
      .list_flat (seq_list),
      .sel       (pos),
      .ch        (conv_ch)
   );

   assign conv_start = (state_q == SEQ_ISSUE);

endmodule

// File: rtl/adc_scan_seq_chk.sv
module adc_scan_seq_chk #(
   parameter int CH_W = 5
) (
   input logic            clk,
   input logic            rst_n,
   input logic            split_en,
   input logic            conv_done,
   input logic            conv_start,
   input logic [CH_W-1:0] conv_ch,
   input logic            eoc,
   input logic            eos
);

   logic split_seen;
   logic pend;
   logic abort_c;

   assign abort_c = split_seen & ~split_en;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         split_seen <= 1'b0;
         pend       <= 1'b0;
      end else begin
         split_seen <= split_en;
         if (abort_c)         pend <= 1'b0;
         else if (conv_start) pend <= 1'b1;
         else if (conv_done)  pend <= 1'b0;
      end
   end

   assert_start_single_R3: assert property (@(posedge clk) disable iff (!rst_n)
      conv_start |=> !conv_start);

   assert_no_stack_R3: assert property (@(posedge clk) disable iff (!rst_n)
      conv_start |-> !pend);

   assert_eoc_from_done_R4: assert property (@(posedge clk) disable iff (!rst_n)
      eoc |-> $past(conv_done));

   assert_done_to_eoc_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (pend && conv_done && !abort_c) |=> eoc);

   assert_eoc_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
      eoc |=> !eoc);

   assert_eos_with_eoc_R5: assert property (@(posedge clk) disable iff (!rst_n)
      eos |-> eoc);

   assert_quiet_after_abort_R9: assert property (@(posedge clk) disable iff (!rst_n)
      abort_c |=> (!conv_start && !eoc && !eos));

   assert_ch_known_R2: assert property (@(posedge clk) disable iff (!rst_n)
      conv_start |-> !$isunknown(conv_ch));

endmodule

bind adc_scan_seq adc_scan_seq_chk #(.CH_W(CH_W)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .split_en   (split_en),
   .conv_done  (conv_done),
   .conv_start (conv_start),
   .conv_ch    (conv_ch),
   .eoc        (eoc),
   .eos        (eos)
);

// File: tb/adc_scan_seq_tb.sv
module adc_scan_seq_tb;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        split_en = 1'b0;
   logic [2:0]  grp_size = '0;
   logic [3:0]  seq_len = '0;
   logic [79:0] seq_list;
   logic        trig = 1'b0;
   logic        conv_done = 1'b0;
   logic        conv_start;
   logic [4:0]  conv_ch;
   logic        eoc;
   logic        eos;

   logic [4:0]  ent_m [16];
   int          n_chk = 0;
   int          n_bad = 0;
   int          pos_m = 0;
   bit          stub_on = 1'b1;

   always #10 clk = ~clk;

   always_comb begin
      for (int i = 0; i < 16; i++) seq_list[i*5 +: 5] = ent_m[i];
   end

   adc_scan_seq u_dut (
      .clk(clk), .rst_n(rst_n), .split_en(split_en), .grp_size(grp_size),
      .seq_len(seq_len), .seq_list(seq_list), .trig(trig), .conv_done(conv_done),
      .conv_start(conv_start), .conv_ch(conv_ch), .eoc(eoc), .eos(eos)
   );

   // behavioural converter: answers each request after 1..3 cycles
   initial begin
      forever begin
         @(negedge clk);
         conv_done = 1'b0;
         if (conv_start && stub_on) begin
            repeat (1 + ($urandom % 3)) @(negedge clk);
            conv_done = 1'b1;
         end
      end
   end

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=%0d expected=%0d t=%0t", req, act, exp, $time);
      end
   endtask

   task automatic summary();
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      n_chk++; n_bad++;
      $display("FAIL R3 watchdog expired actual=1 expected=0");
      summary();
      $finish;
   end

   function automatic int grp_count(input bit sp, input int len, input int n, input int p);
      if (!sp) return len;
      return (len - p < n) ? (len - p) : n;
   endfunction

   task automatic set_cfg(input bit sp, input int len, input int n);
      @(negedge clk); split_en = 1'b0;
      repeat (2) @(negedge clk);
      seq_len  = 4'(len - 1);
      grp_size = 3'(n - 1);
      split_en = sp;
      @(negedge clk);
      pos_m = 0;
   endtask

   task automatic run_trig(input bit inject);
      int    len, n, cnt, idx, t;
      bit    quiet;
      string lab;
      len = int'(seq_len) + 1;
      n   = int'(grp_size) + 1;
      cnt = grp_count(split_en, len, n, pos_m);
      lab = !split_en ? "R2" : ((cnt < n) ? "R7" : "R6");
      @(negedge clk); trig = 1'b1;
      @(negedge clk); trig = 1'b0;
      chk(conv_start == 1'b1, "R2 start follows trigger", int'(conv_start), 1);
      for (int k = 0; k < cnt; k++) begin
         idx = pos_m + k;
         t = 0;
         while (!conv_start && t < 60) begin @(negedge clk); t++; end
         if (!conv_start) begin
            chk(1'b0, "R3 request missing", 0, 1);
            return;
         end
         chk(conv_ch == ent_m[idx], lab, int'(conv_ch), int'(ent_m[idx]));
         @(negedge clk);
         if (inject && k == 0) trig = 1'b1;
         t = 0;
         while (!eoc && t < 60) begin @(negedge clk); trig = 1'b0; t++; end
         trig = 1'b0;
         chk(eoc == 1'b1, "R4 eoc after done", int'(eoc), 1);
         chk(eos == (idx == len - 1), "R5 eos position", int'(eos), int'(idx == len - 1));
      end
      quiet = 1'b1;
      for (int w = 0; w < 6; w++) begin
         if (conv_start) quiet = 1'b0;
         @(negedge clk);
      end
      chk(quiet, inject ? "R8 dropped trigger" : lab, int'(!quiet), 0);
      if (!split_en || pos_m + cnt >= len) pos_m = 0;
      else pos_m = pos_m + cnt;
   endtask

   task automatic abort_mid();
      bit quiet;
      @(negedge clk); trig = 1'b1;
      @(negedge clk); trig = 1'b0;
      @(negedge clk); split_en = 1'b0;
      quiet = 1'b1;
      for (int w = 0; w < 8; w++) begin
         @(negedge clk);
         if (eoc || conv_start || eos) quiet = 1'b0;
      end
      chk(quiet, "R9 abort silences", int'(!quiet), 0);
      split_en = 1'b1;
      @(negedge clk);
      pos_m = 0;
   endtask

   initial begin
      void'($urandom(32'd4242));
      for (int i = 0; i < 16; i++) ent_m[i] = 5'(i * 3 + 1);
      repeat (3) @(negedge clk);
      chk(conv_start == 1'b0, "R1 reset start", int'(conv_start), 0);
      chk(eoc == 1'b0, "R1 reset eoc", int'(eoc), 0);
      chk(eos == 1'b0, "R1 reset eos", int'(eos), 0);
      rst_n = 1'b1;

      // first trigger after reset begins at entry 0 (R1)
      seq_len = 4'd8; grp_size = 3'd2; split_en = 1'b1;
      @(negedge clk);
      run_trig(1'b0); run_trig(1'b0); run_trig(1'b0); run_trig(1'b0);

      // whole-list mode, full length and single entry (R2)
      set_cfg(1'b0, 16, 1); run_trig(1'b0); run_trig(1'b0);
      set_cfg(1'b0, 1, 1);  run_trig(1'b0);

      // shortened last group and wrap (R7)
      set_cfg(1'b1, 5, 3); run_trig(1'b0); run_trig(1'b0); run_trig(1'b0);
      set_cfg(1'b1, 16, 8); run_trig(1'b0); run_trig(1'b0); run_trig(1'b0);

      // trigger while busy (R8)
      set_cfg(1'b1, 6, 4); run_trig(1'b1); run_trig(1'b1);
      set_cfg(1'b0, 7, 1); run_trig(1'b1);

      // rewind on clearing split mode (R9)
      set_cfg(1'b1, 10, 3); run_trig(1'b0);
      @(negedge clk); split_en = 1'b0; @(negedge clk); split_en = 1'b1;
      @(negedge clk); pos_m = 0; run_trig(1'b0);
      run_trig(1'b0); abort_mid(); run_trig(1'b0);

      // randomized configurations
      for (int c = 0; c < 30; c++) begin
         for (int i = 0; i < 16; i++) ent_m[i] = 5'($urandom);
         set_cfg(1'($urandom), 1 + ($urandom % 16), 1 + ($urandom % 8));
         for (int r = 0; r < 4; r++) run_trig(1'($urandom % 4 == 0));
      end

      // reset mid-list rewinds (R1)
      set_cfg(1'b1, 12, 5); run_trig(1'b0);
      @(negedge clk); rst_n = 1'b0; @(negedge clk);
      chk(conv_start == 1'b0 && eoc == 1'b0, "R1 reset clears", int'(conv_start | eoc), 0);
      rst_n = 1'b1; @(negedge clk); pos_m = 0;
      run_trig(1'b0);

      summary();
      $finish;
   end

endmodule